// File: doc/BRIEF.md
# Return-from-Interrupt Stack Pop Sequencer

This block is the part of a processor controller that returns from an interrupt or exception handler. When started, it takes the current stack pointer, status word and saved user stack pointer. It then reads two words from the stack through a simple memory port that has a ready flag: first the saved program counter, then the saved status word. Each word is moved into its architectural register through the memory data register.

The privilege bit of the status word (bit 15, where 1 means user mode) is checked twice. It is checked on entry: a return attempted from user mode does not touch the stack and leaves through a one-cycle fault exit, which hands off to the privilege-violation exception. It is checked again after the restored status word has been loaded. If that word says supervisor mode, the sequencer leaves through a single idle step. If it says user mode, the current stack pointer is saved as the supervisor stack pointer and the stack pointer is reloaded from the saved user value.

The block drives a load strobe for each register it writes, so that a surrounding datapath can follow its progress. It holds the registers it updates, so the final PC, status word and stack pointers can be read at its outputs.

Top module: `rti_pop_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, busy, finish, fault, mem_rd and every load strobe are 0, and pc_out, psr_out, sp_out and ssp_out read 0.
- R2: A start seen while idle latches psr_in, sp_in and usp_in. In the next cycle the sequencer loads the address register from the stack pointer, so that mem_addr equals the latched sp_in one cycle after that.
- R3: If bit 15 of the latched status word is 1 at entry, the sequencer asserts fault and finish for exactly one cycle, issues no memory read, and leaves pc_out, psr_out and sp_out unchanged.
- R4: A memory read holds mem_rd high and mem_addr steady for every cycle in which mem_ready is 0, and it completes in the cycle where mem_ready is 1.
- R5: In a read cycle, ld_mdr is the only load strobe that is high.
- R6: pc_out takes the word read from address SP, where SP is the stack pointer at entry.
- R7: After the PC word, the address register and the stack pointer both step to SP+1. psr_out then takes the word read from SP+1.
- R8: After the status word is restored, the stack pointer steps once more, to SP+2.
- R9: If bit 15 of the restored status word is 0, one idle step follows. The final sp_out is SP+2 and ssp_out is unchanged.
- R10: If bit 15 of the restored status word is 1, ssp_out takes SP+2 and sp_out takes the latched usp_in, both in the same cycle.
- R11: finish is high for exactly one cycle at the end of each run, and busy falls in the following cycle. A start that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a return sequence (sampled when idle) |
| psr_in | input | 16 | Status word at entry; bit 15 is privilege (1 = user) |
| sp_in | input | 16 | Stack pointer at entry |
| usp_in | input | 16 | Saved user stack pointer |
| mem_rdata | input | 16 | Memory read data |
| mem_ready | input | 1 | Memory read complete |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory address (address register) |
| ld_mar | output | 1 | Address register load strobe |
| ld_mdr | output | 1 | Data register load strobe |
| ld_pc | output | 1 | PC load strobe |
| ld_psr | output | 1 | Status word load strobe |
| ld_sp | output | 1 | Stack pointer load strobe |
| ld_ssp | output | 1 | Saved supervisor stack pointer load strobe |
| busy | output | 1 | Sequence in progress |
| finish | output | 1 | Last cycle of a sequence |
| fault | output | 1 | Privilege-violation exit |
| pc_out | output | 16 | Program counter |
| psr_out | output | 16 | Status word |
| sp_out | output | 16 | Stack pointer |
| ssp_out | output | 16 | Saved supervisor stack pointer |

## Verification
Suppose start is sampled at edge k and memory answers at once. mem_addr shows SP after edge k+1. The fault exit is visible after edge k+1. The PC is valid after edge k+3, the status word after k+6, and finish is high between edges k+7 and k+8. The final stack pointer values are valid after edge k+8. Each cycle of memory stall pushes every later result back by one cycle. The bench does not hard-code these offsets. A behavioural model steps once per rising edge, sees the same ready flag as the design, and is compared with every output at each falling edge. Final register values are then checked again once busy has dropped.

// File: rtl/rtip_pkg.sv
package rtip_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CHK, ST_RDPC, ST_LDPC, ST_INC1, ST_RDPSR,
    ST_LDPSR, ST_INC2, ST_NOP, ST_SWAP, ST_FAULT
  } rtip_state_e;

  typedef struct packed {
    logic init;     // capture entry values
    logic mar;      // load address register
    logic mar_inc;  // address register source: SP+1 instead of SP
    logic mdr;      // load data register from memory
    logic pc;       // load PC from data register
    logic psr;      // load status word from data register
    logic sp_inc;   // step stack pointer
    logic sp_usp;   // stack pointer from saved user value
    logic ssp;      // saved supervisor pointer from stack pointer
  } rtip_ctl_t;
endpackage

// File: rtl/rtip_ctrl.sv
module rtip_ctrl
  import rtip_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      priv,
  input  logic      mem_ready,
  output rtip_ctl_t ctl,
  output logic      mem_rd,
  output logic      busy,
  output logic      finish,
  output logic      fault
);
  rtip_state_e st, nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:  if (start) nxt = ST_CHK;
      ST_CHK:   nxt = priv ? ST_FAULT : ST_RDPC;
      ST_RDPC:  if (mem_ready) nxt = ST_LDPC;
      ST_LDPC:  nxt = ST_INC1;
      ST_INC1:  nxt = ST_RDPSR;
      ST_RDPSR: if (mem_ready) nxt = ST_LDPSR;
      ST_LDPSR: nxt = ST_INC2;
      ST_INC2:  nxt = priv ? ST_SWAP : ST_NOP;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl = '0;
    case (st)
      ST_IDLE:  ctl.init = start;
      ST_CHK:   ctl.mar = 1'b1;
      ST_RDPC:  ctl.mdr = 1'b1;
      ST_LDPC:  ctl.pc = 1'b1;
      ST_INC1:  begin ctl.mar = 1'b1; ctl.mar_inc = 1'b1; ctl.sp_inc = 1'b1; end
      ST_RDPSR: ctl.mdr = 1'b1;
      ST_LDPSR: ctl.psr = 1'b1;
      ST_INC2:  ctl.sp_inc = 1'b1;
      ST_SWAP:  begin ctl.sp_usp = 1'b1; ctl.ssp = 1'b1; end
      default:  ctl = '0;
    endcase
  end

  assign mem_rd = (st == ST_RDPC) || (st == ST_RDPSR);
  assign busy   = (st != ST_IDLE);
  assign finish = (st == ST_NOP) || (st == ST_SWAP) || (st == ST_FAULT);
  assign fault  = (st == ST_FAULT);

  // named events for the checks below
  wire ev_stall = mem_rd && !mem_ready;
  wire ev_other_ld = ctl.mar || ctl.pc || ctl.psr || ctl.sp_inc || ctl.sp_usp || ctl.ssp;

  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stall |=> mem_rd);
  assert_read_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !ev_other_ld);
  assert_finish_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (!finish && !busy));
  assert_fault_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!mem_rd && $past(busy) && !$past(mem_rd)));
endmodule

// File: rtl/rtip_regs.sv
module rtip_regs
  import rtip_pkg::*;
#(
  parameter int W        = 16,
  parameter int PRIV_BIT = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  rtip_ctl_t    ctl,
  input  logic [W-1:0] psr_in,
  input  logic [W-1:0] sp_in,
  input  logic [W-1:0] usp_in,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] mar_q,
  output logic [W-1:0] pc_q,
  output logic [W-1:0] psr_q,
  output logic [W-1:0] sp_q,
  output logic [W-1:0] ssp_q,
  output logic         priv
);
  logic [W-1:0] mdr_q, usp_q;

  function automatic logic [W-1:0] f_step(input logic [W-1:0] v);
    return v + {{(W-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mar_q <= '0; mdr_q <= '0; pc_q <= '0; psr_q <= '0;
      sp_q <= '0; ssp_q <= '0; usp_q <= '0;
    end else begin
      if (ctl.init) begin
        psr_q <= psr_in;
        sp_q  <= sp_in;
        usp_q <= usp_in;
      end
      if (ctl.mar)    mar_q <= ctl.mar_inc ? f_step(sp_q) : sp_q;
      if (ctl.mdr)    mdr_q <= mem_rdata;
      if (ctl.pc)     pc_q  <= mdr_q;
      if (ctl.psr)    psr_q <= mdr_q;
      if (ctl.sp_inc) sp_q  <= f_step(sp_q);
      else if (ctl.sp_usp) sp_q <= usp_q;
      if (ctl.ssp)    ssp_q <= sp_q;
    end
  end

  assign priv = psr_q[PRIV_BIT];

  assert_pc_from_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pc |=> (pc_q == $past(mdr_q)));
  assert_sp_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.sp_inc |=> (sp_q == $past(sp_q) + 1'b1));
  assert_stack_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ssp |=> ((ssp_q == $past(sp_q)) && (sp_q == $past(usp_q))));
endmodule

// File: rtl/rti_pop_seq.sv
module rti_pop_seq
  import rtip_pkg::*;
#(
  parameter int W        = 16,
  parameter int PRIV_BIT = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] psr_in,
  input  logic [W-1:0] sp_in,
  input  logic [W-1:0] usp_in,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_ready,
  output logic         mem_rd,
  output logic [W-1:0] mem_addr,
  output logic         ld_mar,
  output logic         ld_mdr,
  output logic         ld_pc,
  output logic         ld_psr,
  output logic         ld_sp,
  output logic         ld_ssp,
  output logic         busy,
  output logic         finish,
  output logic         fault,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] psr_out,
  output logic [W-1:0] sp_out,
  output logic [W-1:0] ssp_out
);
  rtip_ctl_t ctl;
  logic      priv;

  rtip_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .priv(priv), .mem_ready(mem_ready),
    .ctl(ctl), .mem_rd(mem_rd), .busy(busy), .finish(finish), .fault(fault)
  );

  rtip_regs #(.W(W), .PRIV_BIT(PRIV_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .psr_in(psr_in), .sp_in(sp_in),
    .usp_in(usp_in), .mem_rdata(mem_rdata), .mar_q(mem_addr), .pc_q(pc_out),
    .psr_q(psr_out), .sp_q(sp_out), .ssp_q(ssp_out), .priv(priv)
  );

  assign ld_mar = ctl.mar;
  assign ld_mdr = ctl.mdr;
  assign ld_pc  = ctl.pc;
  assign ld_psr = ctl.psr;
  assign ld_sp  = ctl.sp_inc || ctl.sp_usp;
  assign ld_ssp = ctl.ssp;

  assert_fault_keeps_regs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> ($stable(pc_out) && $stable(psr_out) && $stable(sp_out)));
  assert_addr_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> $stable(mem_addr));
endmodule

// File: tb/sim_rti_pop_seq.sv
module sim_rti_pop_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] psr_in = '0, sp_in = '0, usp_in = '0;
  logic [15:0] mem_rdata;
  logic mem_ready;
  logic mem_rd, ld_mar, ld_mdr, ld_pc, ld_psr, ld_sp, ld_ssp, busy, finish, fault;
  logic [15:0] mem_addr, pc_out, psr_out, sp_out, ssp_out;

  always #5 clk = ~clk;

  rti_pop_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .psr_in(psr_in), .sp_in(sp_in),
    .usp_in(usp_in), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .ld_mar(ld_mar), .ld_mdr(ld_mdr), .ld_pc(ld_pc),
    .ld_psr(ld_psr), .ld_sp(ld_sp), .ld_ssp(ld_ssp), .busy(busy), .finish(finish),
    .fault(fault), .pc_out(pc_out), .psr_out(psr_out), .sp_out(sp_out), .ssp_out(ssp_out)
  );

  // bench memory with programmable stall per read
  logic [15:0] mem [256];
  int stall_cfg = 0;
  int stall_cnt = 0;
  assign mem_rdata = mem[mem_addr[7:0]];
  assign mem_ready = (stall_cnt == 0);
  always @(posedge clk) begin
    if (mem_rd) begin
      if (stall_cnt == 0) stall_cnt <= stall_cfg;
      else stall_cnt <= stall_cnt - 1;
    end
  end

  int total = 0, bad = 0, cyc = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  // behavioural reference: phase numbers 0 idle .. 10
  int ph = 0;
  logic [15:0] m_mar = 0, m_mdr = 0, m_pc = 0, m_psr = 0, m_sp = 0, m_ssp = 0, m_usp = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_mar = 0; m_mdr = 0; m_pc = 0; m_psr = 0; m_sp = 0; m_ssp = 0; m_usp = 0;
    end else begin
      case (ph)
        0: if (start) begin m_psr = psr_in; m_sp = sp_in; m_usp = usp_in; ph = 1; end
        1: begin m_mar = m_sp; ph = m_psr[15] ? 9 : 2; end
        2: begin m_mdr = mem[m_mar[7:0]]; if (mem_ready) ph = 3; end
        3: begin m_pc = m_mdr; ph = 4; end
        4: begin m_mar = m_sp + 16'd1; m_sp = m_sp + 16'd1; ph = 5; end
        5: begin m_mdr = mem[m_mar[7:0]]; if (mem_ready) ph = 6; end
        6: begin m_psr = m_mdr; ph = 7; end
        7: begin m_sp = m_sp + 16'd1; ph = m_psr[15] ? 8 : 10; end
        8: begin m_ssp = m_sp; m_sp = m_usp; ph = 0; end
        default: ph = 0;
      endcase
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check("R2 mem_addr", mem_addr, m_mar);
      check("R4 mem_rd", mem_rd, (ph == 2 || ph == 5));
      check("R5 strobes", {ld_mar, ld_mdr, ld_pc, ld_psr, ld_sp, ld_ssp},
            {ph == 1 || ph == 4, ph == 2 || ph == 5, ph == 3, ph == 6,
             ph == 4 || ph == 7 || ph == 8, ph == 8});
      check("R6 pc", pc_out, m_pc);
      check("R7 psr", psr_out, m_psr);
      check("R8 sp", sp_out, m_sp);
      check("R10 ssp", ssp_out, m_ssp);
      check("R3 fault", fault, ph == 9);
      check("R11 busy/finish", {busy, finish}, {ph != 0, ph >= 8});
    end
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(input logic [15:0] p, input logic [15:0] s, input logic [15:0] u,
                     input int stall, input bit poke);
    @(negedge clk);
    stall_cfg = stall; stall_cnt = stall;
    psr_in = p; sp_in = s; usp_in = u; start = 1'b1;
    @(negedge clk);
    start = 1'b0; psr_in = 16'hFFFF; sp_in = 16'h00AA; usp_in = 16'h0BAD;
    if (poke) begin
      // R11: start while busy must be ignored
      repeat (2) @(negedge clk);
      start = 1'b1; psr_in = 16'h0000; sp_in = 16'h0070;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3 + 1);
    mem[8'h40] = 16'h3000; mem[8'h41] = 16'h0002;
    mem[8'h50] = 16'h1234; mem[8'h51] = 16'h8004;
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1 idle", {busy, finish, fault, mem_rd}, 4'b0000);
    check("R1 strobes", {ld_mar, ld_mdr, ld_pc, ld_psr, ld_sp, ld_ssp}, 6'b0);
    check("R1 regs", {pc_out, psr_out, sp_out, ssp_out}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {busy, pc_out, sp_out}, 33'h0);

    // R9: return to supervisor, no stall
    run(16'h0001, 16'h0040, 16'hFE00, 0, 1'b0);
    check("R9 pc", pc_out, 16'h3000);
    check("R9 psr", psr_out, 16'h0002);
    check("R9 sp", sp_out, 16'h0042);
    check("R9 ssp unchanged", ssp_out, 16'h0000);

    // R10: return to user, stalled reads, start poked while busy
    run(16'h0004, 16'h0050, 16'hFE00, 3, 1'b1);
    check("R10 pc", pc_out, 16'h1234);
    check("R10 psr", psr_out, 16'h8004);
    check("R10 sp from usp", sp_out, 16'hFE00);
    check("R10 ssp", ssp_out, 16'h0052);

    // R3: attempt from user mode
    run(16'h8001, 16'h0060, 16'h0123, 1, 1'b0);
    check("R3 pc kept", pc_out, 16'h1234);
    check("R3 psr kept", psr_out, 16'h8001);
    check("R3 sp kept", sp_out, 16'h0060);
    check("R3 ssp kept", ssp_out, 16'h0052);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule